// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This peripheral supervises software through a down-counter that advances once per 10 ms tick-enable supplied by an external prescaler. Software controls it over a single-cycle register bus with 32-bit data, of which only the low 16 bits carry meaning. Every control action is guarded by a fixed 16-bit key value. Turning the watchdog off takes two keyed writes to two different registers, in order. Status registers read back coded 16-bit words rather than single flag bits.

If software stops feeding the watchdog, the counter reaches zero. One tick after that, the block drives a system reset pulse of fixed length and reloads the counter from the programmed timeout. One tick before that expiry, it raises a maskable early-warning event. A timed-out flag records the expiry. This flag is cleared only by the power-on reset or by a keyed write, so it survives the system reset that the block itself triggers. While the chip is in debug mode, counting is suspended unless software sets an override bit.

Top module: `wdk_top`

## Requirements
- R1: After reset the watchdog is disabled. Offset 0x0C reads 0xDABE, the timeout at 0x04 reads 6000, the count at 0x14 reads 6000 in bits 14:0, status at 0x10 reads 0x0000, and `irq_o` and `sys_rst_o` are low.
- R2: Writing 0xFEED to offset 0x00 reloads the count from the timeout register on the next clock. Any other value written there leaves the count unchanged.
- R3: Offset 0x04 stores bits 14:0 of the written data. Bits 15 and up are dropped, so writing 0xFFFF reads back 0x7FFF.
- R4: Writing 0x2BAD to offset 0x08 and then 0xCAFE to offset 0x0C disables the watchdog. Offset 0x0C then reads 0xDABE, and it reads 0x0000 while the watchdog is enabled. Ticks do not change the count while the watchdog is disabled.
- R5: Writing to 0x0C with any value other than 0xCAFE cancels an armed disable sequence. So does writing 0xCAFE when no correct 0x2BAD write came before it. So does writing a wrong value to 0x08. After any of these the watchdog stays enabled.
- R6: Writing 0xACED to offset 0x1C enables the watchdog. Other values written there have no effect.
- R7: While the watchdog is active, each tick decrements the count by one. Offset 0x14 returns the count in bits 14:0. Bit 15 reads 1 in a cycle where `tick_i` is high and the watchdog is active, marking the value as about to change.
- R8: A tick while the active count is 0 reloads the count from the timeout. It also drives `sys_rst_o` high for exactly RST_CYCLES clocks, starting on the next clock. A second expiry while the pulse is running is ignored.
- R9: After an expiry, offset 0x10 reads 0xCFE8. The flag survives `rst_ni` and is cleared only by `por_ni` or by writing 0xE8B4 to 0x10. Other values written there have no effect.
- R10: The warning event, offset 0x20 bit 0, is set by the tick that takes the count from 1 to 0. It is also set by writing 1 to bit 0 of 0x28. Writing 1 to bit 0 of 0x20 clears it, and a set in the same cycle wins. `irq_o` equals the event ANDed with mask bit 0 of 0x24.
- R11: Bit 1 of offset 0x18 reads `dbg_mode_i`. While `dbg_mode_i` is high and bit 0 of 0x18 is 0, ticks do not change the count. With bit 0 at 1, counting continues during debug mode.
- R12: A read of an unmapped offset (for example 0x2C) returns 0, and `rdata_o` is 0 while no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| por_ni | input | 1 | Active-low asynchronous power-on reset; clears the timed-out flag and the reset pulse |
| tick_i | input | 1 | 10 ms count enable from an external prescaler |
| dbg_mode_i | input | 1 | Debug mode is active |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write (1) or read (0) |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | DATA_W | Write data; bits 15:0 used |
| rdata_o | output | DATA_W | Read data, valid in the same cycle as the read strobe |
| irq_o | output | 1 | Early-warning interrupt |
| sys_rst_o | output | 1 | System reset pulse on expiry |

## Verification
A corrupted count becomes visible at the count register on the next read. After one more tick, it also shows up as an early or late warning event, and then as a reset pulse on the wrong tick. Sweeping the timeout over small values pins down, for each tick, both the count and the point of expiry. A lost or wrongly armed disable sequence shows at offset 0x0C in the cycle after the second key. A status flag cleared by the wrong reset shows up as 0x0000 at 0x10 right after `rst_ni` is pulsed.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int unsigned KEY_W = 16;

  localparam logic [5:0] OFS_FEED  = 6'h00;
  localparam logic [5:0] OFS_TMO   = 6'h04;
  localparam logic [5:0] OFS_DIS_A = 6'h08;
  localparam logic [5:0] OFS_DIS_B = 6'h0C;
  localparam logic [5:0] OFS_STAT  = 6'h10;
  localparam logic [5:0] OFS_CNT   = 6'h14;
  localparam logic [5:0] OFS_DBG   = 6'h18;
  localparam logic [5:0] OFS_RSTRT = 6'h1C;
  localparam logic [5:0] OFS_EVT   = 6'h20;
  localparam logic [5:0] OFS_MASK  = 6'h24;
  localparam logic [5:0] OFS_FORCE = 6'h28;

  localparam logic [KEY_W-1:0] KEY_FEED  = 16'hFEED;
  localparam logic [KEY_W-1:0] KEY_DIS_A = 16'h2BAD;
  localparam logic [KEY_W-1:0] KEY_DIS_B = 16'hCAFE;
  localparam logic [KEY_W-1:0] KEY_RSTRT = 16'hACED;
  localparam logic [KEY_W-1:0] KEY_CLR   = 16'hE8B4;

  localparam logic [KEY_W-1:0] CODE_OFF  = 16'hDABE;
  localparam logic [KEY_W-1:0] CODE_TRIP = 16'hCFE8;
endpackage

// File: rtl/wdk_regs.sv
module wdk_regs
  import wdk_pkg::*;
#(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CNT_W   = 15,
  parameter int unsigned TMO_RST = 6000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [KEY_W-1:0]  wkey_i,
  input  logic              dbg_mode_i,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              warn_i,
  input  logic              trip_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  timeout_o,
  output logic              feed_o,
  output logic              active_o,
  output logic              event_o,
  output logic              timed_out_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] timeout_q;
  logic enabled_q, armed_q, ovr_q, mask_q, event_q, timed_out_q;
  logic wr, rd;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [5:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign feed_o   = wr && hit(addr_i, OFS_FEED) && (wkey_i == KEY_FEED);
  assign active_o = enabled_q & (~dbg_mode_i | ovr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timeout_q <= CNT_W'(TMO_RST);
      enabled_q <= 1'b0;
      armed_q   <= 1'b0;
      ovr_q     <= 1'b0;
      mask_q    <= 1'b0;
      event_q   <= 1'b0;
    end else begin
      if (wr && hit(addr_i, OFS_TMO)) timeout_q <= wkey_i[CNT_W-1:0];
      if (wr && hit(addr_i, OFS_DBG)) ovr_q <= wkey_i[0];
      if (wr && hit(addr_i, OFS_MASK)) mask_q <= wkey_i[0];
      // two-step disable: first key arms, any touch of the second register disarms
      if (wr && hit(addr_i, OFS_DIS_A)) armed_q <= (wkey_i == KEY_DIS_A);
      else if (wr && hit(addr_i, OFS_DIS_B)) armed_q <= 1'b0;
      if (wr && hit(addr_i, OFS_DIS_B) && armed_q && (wkey_i == KEY_DIS_B))
        enabled_q <= 1'b0;
      else if (wr && hit(addr_i, OFS_RSTRT) && (wkey_i == KEY_RSTRT))
        enabled_q <= 1'b1;
      if (warn_i || (wr && hit(addr_i, OFS_FORCE) && wkey_i[0]))
        event_q <= 1'b1;
      else if (wr && hit(addr_i, OFS_EVT) && wkey_i[0])
        event_q <= 1'b0;
    end
  end

  // status lives on the power-on reset so it outlasts the reset it causes
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) timed_out_q <= 1'b0;
    else if (trip_i) timed_out_q <= 1'b1;
    else if (wr && hit(addr_i, OFS_STAT) && (wkey_i == KEY_CLR)) timed_out_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        ADDR_W'(OFS_TMO):   rdata_o[CNT_W-1:0] = timeout_q;
        ADDR_W'(OFS_DIS_B): rdata_o[KEY_W-1:0] = enabled_q ? '0 : CODE_OFF;
        ADDR_W'(OFS_STAT):  rdata_o[KEY_W-1:0] = timed_out_q ? CODE_TRIP : '0;
        ADDR_W'(OFS_CNT):   rdata_o[CNT_W:0]   = {tick_i & active_o, count_i};
        ADDR_W'(OFS_DBG):   rdata_o[1:0]       = {dbg_mode_i, ovr_q};
        ADDR_W'(OFS_EVT):   rdata_o[0]         = event_q;
        ADDR_W'(OFS_MASK):  rdata_o[0]         = mask_q;
        default:            rdata_o            = '0;
      endcase
    end
  end

  assign timeout_o   = timeout_q;
  assign event_o     = event_q;
  assign timed_out_o = timed_out_q;
  assign irq_o       = event_q & mask_q;
endmodule

// File: rtl/wdk_count.sv
module wdk_count #(
  parameter int unsigned CNT_W   = 15,
  parameter int unsigned TMO_RST = 6000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             active_i,
  input  logic             feed_i,
  input  logic [CNT_W-1:0] timeout_i,
  output logic [CNT_W-1:0] count_o,
  output logic             warn_o,
  output logic             trip_o
);
  logic [CNT_W-1:0] count_q;
  logic step;

  assign step   = tick_i & active_i & ~feed_i;
  assign trip_o = step && (count_q == '0);
  assign warn_o = step && (count_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                count_q <= CNT_W'(TMO_RST);
    else if (feed_i || trip_o)  count_q <= timeout_i;
    else if (step)              count_q <= count_q - 1'b1;
  end

  assign count_o = count_q;
endmodule

// File: rtl/wdk_pulse.sv
module wdk_pulse #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic por_ni,
  input  logic trip_i,
  output logic pulse_o
);
  localparam int unsigned LW = $clog2(LEN + 1);
  logic [LW-1:0] left_q;

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)                       left_q <= '0;
    else if (trip_i && left_q == '0)   left_q <= LW'(LEN);
    else if (left_q != '0)             left_q <= left_q - 1'b1;
  end

  assign pulse_o = (left_q != '0);
endmodule

// File: rtl/wdk_top.sv
module wdk_top
  import wdk_pkg::*;
#(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned CNT_W      = 15,
  parameter int unsigned TMO_RST    = 6000,
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              tick_i,
  input  logic              dbg_mode_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              sys_rst_o
);
  logic [CNT_W-1:0] timeout_w, count_w;
  logic feed_w, active_w, warn_w, trip_w, event_w, timed_out_w;
  logic unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:KEY_W];

  wdk_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .TMO_RST(TMO_RST)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .por_ni(por_ni),
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .wkey_i(wdata_i[KEY_W-1:0]),
    .dbg_mode_i(dbg_mode_i), .tick_i(tick_i), .count_i(count_w),
    .warn_i(warn_w), .trip_i(trip_w),
    .rdata_o(rdata_o), .timeout_o(timeout_w), .feed_o(feed_w),
    .active_o(active_w), .event_o(event_w), .timed_out_o(timed_out_w),
    .irq_o(irq_o)
  );

  wdk_count #(.CNT_W(CNT_W), .TMO_RST(TMO_RST)) u_count (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .active_i(active_w),
    .feed_i(feed_w), .timeout_i(timeout_w),
    .count_o(count_w), .warn_o(warn_w), .trip_o(trip_w)
  );

  wdk_pulse #(.LEN(RST_CYCLES)) u_pulse (
    .clk_i(clk_i), .por_ni(por_ni), .trip_i(trip_w), .pulse_o(sys_rst_o)
  );
endmodule

// File: rtl/wdk_chk.sv
module wdk_chk #(
  parameter int unsigned CNT_W      = 15,
  parameter int unsigned RST_CYCLES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             por_ni,
  input logic             tick_i,
  input logic             sys_rst_o,
  input logic             irq_o,
  input logic             active_w,
  input logic             feed_w,
  input logic             warn_w,
  input logic             event_w,
  input logic             timed_out_w,
  input logic [CNT_W-1:0] count_w
);
  localparam int unsigned HW = $clog2(RST_CYCLES + 2);
  logic [HW-1:0] hi_len_q;

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)        hi_len_q <= '0;
    else if (sys_rst_o) hi_len_q <= (hi_len_q == HW'(RST_CYCLES + 1)) ? hi_len_q : hi_len_q + 1'b1;
    else                hi_len_q <= '0;
  end

  // R4 / R11: idle watchdog leaves the count alone
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (!active_w && !feed_w) |=> $stable(count_w));

  p_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (active_w && tick_i && !feed_w && count_w != '0) |=> (count_w + 1'b1 == $past(count_w)));

  p_trip_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    $rose(sys_rst_o) |-> $past(active_w && tick_i && !feed_w && count_w == '0));

  p_len_r8: assert property (@(posedge clk_i) disable iff (!por_ni)
    sys_rst_o |-> (hi_len_q < HW'(RST_CYCLES)));

  p_flag_r9: assert property (@(posedge clk_i) disable iff (!por_ni)
    $rose(timed_out_w) |-> sys_rst_o);

  p_warn_r10: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    warn_w |=> event_w);

  p_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    irq_o |-> event_w);
endmodule

bind wdk_top wdk_chk #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .por_ni(por_ni), .tick_i(tick_i),
  .sys_rst_o(sys_rst_o), .irq_o(irq_o), .active_w(active_w), .feed_w(feed_w),
  .warn_w(warn_w), .event_w(event_w), .timed_out_w(timed_out_w), .count_w(count_w)
);

// File: tb/sim_wdk_top.sv
module sim_wdk_top;
  localparam int unsigned RSTC = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, por_ni = 1'b0, tick_i = 1'b0, dbg = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, srst;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  wdk_top #(.RST_CYCLES(RSTC)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .por_ni(por_ni), .tick_i(tick_i),
    .dbg_mode_i(dbg), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .sys_rst_o(srst)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = {16'hA5A5, d};
    cyc();
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic tick();
    tick_i = 1'b1; cyc(); tick_i = 1'b0;
  endtask

  task automatic expect_rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic run();
    logic [31:0] d;
    int n;
    repeat (3) cyc();
    por_ni = 1'b1; rst_ni = 1'b1;
    cyc();
    // R1 reset state
    expect_rd("R1", 6'h0C, 32'hDABE);
    expect_rd("R1", 6'h04, 32'd6000);
    expect_rd("R1", 6'h14, 32'd6000);
    expect_rd("R1", 6'h10, 32'h0);
    chk("R1", {30'd0, irq, srst}, 32'h0);
    // R12 unmapped and idle bus
    expect_rd("R12", 6'h2C, 32'h0);
    #1 chk("R12", rdata, 32'h0);
    // R6 restart key
    wr(6'h1C, 16'h1234);
    expect_rd("R6", 6'h0C, 32'hDABE);
    wr(6'h1C, 16'hACED);
    expect_rd("R6", 6'h0C, 32'h0);
    // R3 timeout width
    wr(6'h04, 16'hFFFF);
    expect_rd("R3", 6'h04, 32'h7FFF);
    // R4 disable sequence
    wr(6'h08, 16'h2BAD); wr(6'h0C, 16'hCAFE);
    expect_rd("R4", 6'h0C, 32'hDABE);
    wr(6'h1C, 16'hACED);
    // R5 broken sequences
    wr(6'h08, 16'h2BAD); wr(6'h0C, 16'h1234); wr(6'h0C, 16'hCAFE);
    expect_rd("R5", 6'h0C, 32'h0);
    wr(6'h0C, 16'hCAFE);
    expect_rd("R5", 6'h0C, 32'h0);
    wr(6'h08, 16'h1111); wr(6'h0C, 16'hCAFE);
    expect_rd("R5", 6'h0C, 32'h0);
    // R2 feed
    wr(6'h04, 16'd20); wr(6'h00, 16'hFEED);
    expect_rd("R2", 6'h14, 32'd20);
    repeat (3) tick();
    expect_rd("R7", 6'h14, 32'd17);
    wr(6'h00, 16'hBEEF);
    expect_rd("R2", 6'h14, 32'd17);
    wr(6'h00, 16'hFEED);
    expect_rd("R2", 6'h14, 32'd20);
    // R7 busy bit during a tick
    tick_i = 1'b1; req = 1'b1; we = 1'b0; addr = 6'h14;
    #1 chk("R7", rdata, 32'h8014);
    req = 1'b0; cyc(); tick_i = 1'b0;
    expect_rd("R7", 6'h14, 32'd19);
    // R11 debug gate
    dbg = 1'b1;
    expect_rd("R11", 6'h18, 32'h2);
    tick();
    expect_rd("R11", 6'h14, 32'd19);
    wr(6'h18, 16'h1);
    expect_rd("R11", 6'h18, 32'h3);
    tick();
    expect_rd("R11", 6'h14, 32'd18);
    wr(6'h18, 16'h0); dbg = 1'b0;
    tick();
    expect_rd("R11", 6'h14, 32'd17);
    // R4 disabled ignores ticks
    wr(6'h08, 16'h2BAD); wr(6'h0C, 16'hCAFE);
    tick();
    expect_rd("R4", 6'h14, 32'd17);
    wr(6'h1C, 16'hACED);
    // R10 force, mask, clear
    wr(6'h24, 16'h0); wr(6'h28, 16'h1);
    expect_rd("R10", 6'h20, 32'h1);
    chk("R10", {31'd0, irq}, 32'h0);
    wr(6'h24, 16'h1);
    chk("R10", {31'd0, irq}, 32'h1);
    wr(6'h20, 16'h0);
    expect_rd("R10", 6'h20, 32'h1);
    wr(6'h20, 16'h1);
    expect_rd("R10", 6'h20, 32'h0);
    chk("R10", {31'd0, irq}, 32'h0);
    // sweep timeouts: count, warning, expiry, pulse, status
    for (int t = 1; t <= 6; t++) begin
      wr(6'h04, 16'(t)); wr(6'h20, 16'h1); wr(6'h00, 16'hFEED);
      expect_rd("R2", 6'h14, 32'(t));
      for (int k = 1; k <= t; k++) begin
        tick();
        expect_rd("R7", 6'h14, 32'(t - k));
        expect_rd("R10", 6'h20, (k == t) ? 32'h1 : 32'h0);
        chk("R10", {31'd0, irq}, (k == t) ? 32'h1 : 32'h0);
        chk("R8", {31'd0, srst}, 32'h0);
      end
      tick();
      chk("R8", {31'd0, srst}, 32'h1);
      expect_rd("R8", 6'h14, 32'(t));
      expect_rd("R9", 6'h10, 32'hCFE8);
      n = 0;
      while (srst && n < 50) begin n++; cyc(); end
      chk("R8", 32'(n), 32'(RSTC));
      if (t < 6) begin
        wr(6'h10, 16'h1234);
        expect_rd("R9", 6'h10, 32'hCFE8);
        wr(6'h10, 16'hE8B4);
        expect_rd("R9", 6'h10, 32'h0);
      end
    end
    // R9 flag outlives the system reset
    rst_ni = 1'b0; cyc(); rst_ni = 1'b1; cyc();
    expect_rd("R9", 6'h10, 32'hCFE8);
    expect_rd("R1", 6'h0C, 32'hDABE);
    wr(6'h10, 16'hE8B4);
    expect_rd("R9", 6'h10, 32'h0);
    rd(6'h14, d);
    chk("R1", d, 32'd6000);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule